// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block holds the hazard logic of a five-stage in-order integer pipeline with the stages fetch, decode/register-read, execute, memory and writeback. It looks at the two source register numbers of the instruction now in decode. It compares them with the destination numbers and write enables of the instructions now in execute and in memory. From these comparisons it picks, one cycle ahead, the operand source that each ALU input will need once the decoded instruction reaches execute. The source is the register file, the memory-stage result or the writeback-stage result. A chain of dependent ALU instructions therefore runs at full rate.

A load in execute whose destination is read by the instruction in decode cannot be bypassed in time. For that case the block raises a hold for the PC and the fetch/decode register and a flush that zeroes the control fields entering execute. The pipeline then behaves as if a nop had been placed between the two instructions. One cycle later the dependent instruction is decoded again, and the loaded value reaches it through the writeback bypass. No bypass from writeback into decode exists, because the register file writes early in the cycle and reads late in it.

Top module: `hazard_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both operand selects become 2'b00 (register file) after that edge.
- R2: If the execute stage writes a nonzero register that equals a decode source, and no flush is raised, that operand's select is 2'b01 (memory-stage result) after the next rising edge.
- R3: If the memory stage writes a nonzero register that equals a decode source, the execute stage does not match it, and no flush is raised, that operand's select is 2'b10 (writeback-stage result) after the next edge.
- R4: When the execute-stage and memory-stage destinations both match the same source, the select is 2'b01, so the younger producer wins.
- R5: Source register 0 never yields a nonzero select and never raises a hold or flush, whatever the write enables and load flag are.
- R6: `front_hold` and `ex_flush` are high in the same cycle that an execute-stage load (`ex_mem_rd`=1, `ex_wr_en`=1) writes a nonzero register equal to either decode source. They are combinational and low otherwise.
- R7: After a rising edge at which `ex_flush` was high, both selects are 2'b00, which is the state of the injected bubble.
- R8: A producer whose write enable is low, or whose destination matches no source, gives select 2'b00 and raises no hold. The value 2'b11 never appears.
- R9: The two operands are resolved independently: a match on one source does not change the other source's select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs_a | input | REG_AW | First source register of the decode-stage instruction |
| dec_rs_b | input | REG_AW | Second source register of the decode-stage instruction |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes its destination |
| ex_mem_rd | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes its destination |
| fwd_sel_a | output | 2 | Registered source select for ALU operand A (00 file, 01 memory, 10 writeback) |
| fwd_sel_b | output | 2 | Registered source select for ALU operand B |
| front_hold | output | 1 | Hold the PC and the fetch/decode register this cycle |
| ex_flush | output | 1 | Zero the control fields entering execute this cycle |

## Verification
The properties assume that the stage inputs describe a real pipeline: they change only between clock edges, and a load-use hold keeps the same decode sources for the cycle that follows. The stimulus drives every input on the falling edge. In its directed load-use sequence it repeats the held decode instruction while a bubble with write enable low occupies execute and the load moves on to memory. The random phase draws register numbers from a range of four, including zero, so that matches, double matches and load-use cases occur often. It does not model pipeline advance, so it checks each cycle only against the reference model.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_FILE = 2'b00,
    SRC_MEM  = 2'b01,
    SRC_WB   = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/operand_src_pick.sv
module operand_src_pick
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr_en,
  output opnd_src_e         nxt_src
);
  logic rs_live, hit_ex, hit_mem;

  always_comb begin
    rs_live = (rs != '0);
    hit_ex  = rs_live && ex_wr_en  && (ex_rd  == rs);
    hit_mem = rs_live && mem_wr_en && (mem_rd == rs);
    // younger producer (now in execute, next in memory) has priority
    if (hit_ex)       nxt_src = SRC_MEM;
    else if (hit_mem) nxt_src = SRC_WB;
    else              nxt_src = SRC_FILE;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] srcs,
  input  logic [REG_AW-1:0]              ex_rd,
  input  logic                           ex_wr_en,
  input  logic                           ex_mem_rd,
  output logic                           hazard
);
  logic [NUM_SRC-1:0] hit;
  logic               load_live;

  assign load_live = ex_mem_rd && ex_wr_en && (ex_rd != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign hit[i] = load_live && (srcs[i] == ex_rd);
  end

  assign hazard = |hit;
endmodule

// File: rtl/src_sel_reg.sv
module src_sel_reg #(
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bubble,
  input  logic [NUM_SRC-1:0][SEL_W-1:0] nxt,
  output logic [NUM_SRC-1:0][SEL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) q <= '0;
    else               q <= nxt;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] dec_rs_a,
  input  logic [REG_AW-1:0] dec_rs_b,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr_en,
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr_en,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              front_hold,
  output logic              ex_flush
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
  logic [NUM_SRC-1:0][SEL_W-1:0]  nxt_sel, cur_sel;
  logic                           lu_hazard;

  assign srcs[0] = dec_rs_a;
  assign srcs[1] = dec_rs_b;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    opnd_src_e pick;
    operand_src_pick #(.REG_AW(REG_AW)) u_pick (
      .rs        (srcs[i]),
      .ex_rd     (ex_rd),
      .ex_wr_en  (ex_wr_en),
      .mem_rd    (mem_rd),
      .mem_wr_en (mem_wr_en),
      .nxt_src   (pick)
    );
    assign nxt_sel[i] = pick;
  end

  load_use_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_lu (
    .srcs      (srcs),
    .ex_rd     (ex_rd),
    .ex_wr_en  (ex_wr_en),
    .ex_mem_rd (ex_mem_rd),
    .hazard    (lu_hazard)
  );

  src_sel_reg #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .bubble (lu_hazard),
    .nxt    (nxt_sel),
    .q      (cur_sel)
  );

  assign fwd_sel_a  = cur_sel[0];
  assign fwd_sel_b  = cur_sel[1];
  assign front_hold = lu_hazard;
  assign ex_flush   = lu_hazard;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] dec_rs_a,
  input logic [REG_AW-1:0] dec_rs_b,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_wr_en,
  input logic              ex_mem_rd,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wr_en,
  input logic [1:0]        fwd_sel_a,
  input logic [1:0]        fwd_sel_b,
  input logic              front_hold,
  input logic              ex_flush
);
  assert_bubble_clears_R7: assert property (@(posedge clk) disable iff (rst)
    ex_flush |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

  assert_ex_match_mem_path_R2: assert property (@(posedge clk) disable iff (rst)
    (!ex_flush && ex_wr_en && ex_rd != '0 && ex_rd == dec_rs_a) |=> fwd_sel_a == 2'b01);

  assert_mem_match_wb_path_R3: assert property (@(posedge clk) disable iff (rst)
    (!ex_flush && mem_wr_en && mem_rd != '0 && mem_rd == dec_rs_b &&
     !(ex_wr_en && ex_rd == dec_rs_b)) |=> fwd_sel_b == 2'b10);

  assert_zero_not_bypassed_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_rs_a == '0) |=> fwd_sel_a == 2'b00);

  assert_zero_no_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_rs_a == '0 && dec_rs_b == '0) |-> !front_hold);

  assert_no_hold_without_load_R6: assert property (@(posedge clk) disable iff (rst)
    !ex_mem_rd |-> !front_hold && !ex_flush);

  assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
    fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);
endmodule

bind hazard_unit hazard_unit_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] dec_rs_a = '0, dec_rs_b = '0, ex_rd = '0, mem_rd = '0;
  logic          ex_wr_en = 1'b0, ex_mem_rd = 1'b0, mem_wr_en = 1'b0;
  logic [1:0]    fwd_sel_a, fwd_sel_b;
  logic          front_hold, ex_flush;

  int checks = 0;
  int fails  = 0;
  int exp_a  = 0;
  int exp_b  = 0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  hazard_unit #(.REG_AW(AW)) uut (.*);

  function automatic int pick(input int rs);
    if (rs != 0 && ex_wr_en && int'(ex_rd) == rs)   return 1;
    if (rs != 0 && mem_wr_en && int'(mem_rd) == rs) return 2;
    return 0;
  endfunction

  function automatic bit stall_now();
    return ex_mem_rd && ex_wr_en && ex_rd != 0 &&
           (ex_rd == dec_rs_a || ex_rd == dec_rs_b);
  endfunction

  // reference model: the selects follow one edge behind the decode view
  always @(posedge clk) begin
    if (rst || stall_now()) begin
      exp_a = 0; exp_b = 0;
    end else begin
      exp_a = pick(int'(dec_rs_a));
      exp_b = pick(int'(dec_rs_b));
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input int a, input int b, input int erd,
                      input bit ewe, input bit emr, input int mrd, input bit mwe);
    @(negedge clk);
    check(last_tag, "fwd_sel_a", int'(fwd_sel_a), exp_a);
    check(last_tag, "fwd_sel_b", int'(fwd_sel_b), exp_b);
    dec_rs_a = AW'(a); dec_rs_b = AW'(b); ex_rd = AW'(erd);
    ex_wr_en = ewe; ex_mem_rd = emr; mem_rd = AW'(mrd); mem_wr_en = mwe;
    #1;
    check(tag, "front_hold", int'(front_hold), int'(stall_now()));
    check(tag, "ex_flush",   int'(ex_flush),   int'(stall_now()));
    last_tag = tag;
  endtask

  initial begin
    // R1: reset with producers that would otherwise match
    dec_rs_a = 5'd3; ex_rd = 5'd3; ex_wr_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fwd_sel_a", int'(fwd_sel_a), 0);
    check("R1", "fwd_sel_b", int'(fwd_sel_b), 0);
    rst = 1'b0;
    step("R8", 1, 2, 3, 1, 0, 4, 1);     // independent
    step("R8", 6, 7, 6, 0, 1, 7, 0);     // matches but write enables low
    step("R2", 5, 1, 5, 1, 0, 0, 0);     // execute producer
    step("R2", 6, 5, 6, 1, 0, 5, 1);     // ALU chain
    step("R9", 6, 7, 7, 1, 0, 0, 0);     // only operand B matches
    step("R3", 8, 2, 3, 1, 0, 8, 1);     // memory-stage producer
    step("R4", 9, 9, 9, 1, 0, 9, 1);     // both match
    step("R5", 0, 0, 0, 1, 1, 0, 1);     // register zero
    step("R6", 10, 4, 10, 1, 1, 3, 1);   // load-use on A
    step("R7", 10, 4, 0, 0, 0, 10, 1);   // bubble in execute, load in memory
    step("R3", 11, 12, 1, 1, 0, 2, 1);   // shows A resolved to writeback
    step("R6", 13, 14, 14, 1, 1, 0, 0);  // load-use on B
    step("R7", 13, 14, 0, 0, 0, 14, 1);
    step("R8", 15, 16, 15, 0, 1, 0, 0);  // load with write disabled
    step("R5", 0, 2, 0, 1, 1, 0, 0);
    for (int i = 0; i < 400; i++)
      step("R4", $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
    step("R8", 1, 2, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule